// File: doc/BRIEF.md
# Round-Robin Temperature Poll Scheduler

This block decides when each of up to eight temperature sources is read. A source slot is numbered `socket*2 + domain`, so four sockets with two domains each fill slots 0 to 7. One enable bit per slot picks the slots that take part. A sweep visits the enabled slots in ascending order. Between two reads of the same sweep the block waits a fixed minimum gap. After the last read of a sweep it pauses for a delay chosen by a 3-bit code, and one code value turns off automatic sweeps altogether. Each read is handed to an external transaction engine through a simple hold-until-done handshake. A failed read is reissued until a configured retry budget is spent.

Every slot keeps a 16-bit result word. That word holds either the last good reading or a status code in the reserved range 8000h-81FFh. A query port returns, one cycle after it is strobed, one of these: a slot's result, the signed maximum over the enabled slots, or the slot index that won the last maximum query. All timing counts a `tick` input. The default `GAP_TICKS` of 5 assumes a 0.5 ms tick, so the gap is 2.5 ms.

Top module: `poll_sched`

## Requirements
- R1: Enable bit n of `en_mask` enables slot n. After reset there is no request, `q_data` is 0000h, and the delay counter is empty, so the first tick under an active delay code starts a sweep.
- R2: Within a sweep, the next read request rises exactly `GAP_TICKS` ticks after the previous read completes.
- R3: After the last read of a sweep, the pause in ticks is `GAP_TICKS` times 1, 2, 4, 20, 40 or 200 for delay codes 1 to 6. Codes 0 and 7 never start a sweep on their own.
- R4: A failed read (`rd_done` with `rd_ok` low) is reissued at once for the same slot, up to `retry_max` retries. When the last retry also fails, the slot result becomes 8100h.
- R5: Querying a disabled slot returns 8101h. An enabled slot whose first poll has not completed returns 8102h. This covers every slot after reset and any slot whose enable bit has just risen.
- R6: The maximum query (selector 8) returns the largest signed result among enabled slots. It skips results in 8000h-81FFh, and a tie goes to the lowest slot. If no valid value exists, it returns 8103h.
- R7: The maximum-address query (selector 10) returns the winning slot index from the last maximum query. If no maximum query was made, or the last one returned 8103h, it returns 8103h.
- R8: A `poll_req` pulse while the block is idle starts one sweep on the next cycle. A pulse during a sweep is dropped.
- R9: A sweep requests enabled slots in ascending index order and skips disabled slots. `rd_req` and `rd_slot` stay unchanged until `rd_done`.
- R10: `q_data` is updated one cycle after `q_rd`. Selectors 0-7 address slots, 8 is the maximum and 10 the maximum address. Any other selector returns 0000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Time base pulse for all timers |
| en_mask | input | 8 | Slot enable bits, bit n = slot n |
| delay_code | input | 3 | Inter-sweep pause code |
| retry_max | input | 8 | Retries allowed after a failed read |
| poll_req | input | 1 | Pulse that starts one sweep |
| rd_req | output | 1 | Read request to the transaction engine |
| rd_slot | output | 3 | Slot being read |
| rd_done | input | 1 | Engine finished the current read |
| rd_ok | input | 1 | Read succeeded, qualifies `rd_done` |
| rd_data | input | 16 | Read data, valid with `rd_done` |
| q_rd | input | 1 | Query strobe |
| q_sel | input | 4 | Query selector |
| q_data | output | 16 | Query result, one cycle after `q_rd` |

## Verification
Some faults change only the request pattern. A wrong gap or pause counter, or a wrong scan pointer, shows on `rd_req`/`rd_slot` as a wrong low interval or a wrong slot order within the same sweep. A broken retry counter shows up on the request line within a few read attempts, either as a missing reissue or an extra one. Faults in the stored results or the maximum search stay hidden until a query. For that reason every sweep is followed by a query of all slots, the maximum and its address, compared against a model of the engine's replies.

// File: rtl/poll_sched.sv
module poll_sched #(
  parameter int SLOTS     = 8,
  parameter int GAP_TICKS = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tick,
  input  logic [SLOTS-1:0]         en_mask,
  input  logic [2:0]               delay_code,
  input  logic [7:0]               retry_max,
  input  logic                     poll_req,
  output logic                     rd_req,
  output logic [$clog2(SLOTS)-1:0] rd_slot,
  input  logic                     rd_done,
  input  logic                     rd_ok,
  input  logic [15:0]              rd_data,
  input  logic                     q_rd,
  input  logic [3:0]               q_sel,
  output logic [15:0]              q_data
);
  localparam int SW = $clog2(SLOTS);
  localparam int CW = $clog2(GAP_TICKS * 200 + 1);
  localparam logic [15:0] ERR_RETRY = 16'h8100;
  localparam logic [15:0] ERR_DIS   = 16'h8101;
  localparam logic [15:0] ERR_FRESH = 16'h8102;
  localparam logic [15:0] ERR_NOMAX = 16'h8103;

  typedef enum logic [1:0] {ST_WAIT, ST_BUSY, ST_GAP} st_t;

  st_t             st;
  logic [CW-1:0]   cnt, pause;
  logic [SW-1:0]   cur, first_i, next_i, mx_i, lm_idx;
  logic            first_v, next_v, mx_v, lm_ok, start, sweep_on;
  logic [7:0]      tries;
  logic [15:0]     res [SLOTS];
  logic [15:0]     mx;
  logic [SLOTS-1:0] en_q;

  assign rd_req   = (st == ST_BUSY);
  assign rd_slot  = cur;
  assign sweep_on = (pause != '0);
  assign start    = (st == ST_WAIT) && (poll_req || (sweep_on && tick && cnt <= CW'(1)));

  always_comb begin
    case (delay_code)
      3'd1:    pause = CW'(GAP_TICKS);
      3'd2:    pause = CW'(GAP_TICKS * 2);
      3'd3:    pause = CW'(GAP_TICKS * 4);
      3'd4:    pause = CW'(GAP_TICKS * 20);
      3'd5:    pause = CW'(GAP_TICKS * 40);
      3'd6:    pause = CW'(GAP_TICKS * 200);
      default: pause = '0;
    endcase
  end

  always_comb begin
    first_v = 1'b0; first_i = '0; next_v = 1'b0; next_i = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (en_mask[i]) begin
        first_v = 1'b1; first_i = SW'(i);
        if (SW'(i) > cur) begin next_v = 1'b1; next_i = SW'(i); end
      end
    end
  end

  always_comb begin
    mx_v = 1'b0; mx = '0; mx_i = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (en_mask[i] && res[i][15:9] != 7'h40 && (!mx_v || $signed(res[i]) > $signed(mx))) begin
        mx_v = 1'b1; mx = res[i]; mx_i = SW'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_WAIT; cnt <= '0; cur <= '0; tries <= '0; en_q <= '0;
      lm_ok <= 1'b0; lm_idx <= '0; q_data <= '0;
      for (int i = 0; i < SLOTS; i++) res[i] <= ERR_FRESH;
    end else begin
      en_q <= en_mask;
      case (st)
        ST_WAIT: begin
          if (start) begin
            if (first_v) begin st <= ST_BUSY; cur <= first_i; tries <= '0; end
            else cnt <= pause;
          end else if (sweep_on && tick) cnt <= cnt - CW'(1);
        end
        ST_BUSY: begin
          if (rd_done) begin
            if (rd_ok || tries == retry_max) begin
              res[cur] <= rd_ok ? rd_data : ERR_RETRY;
              tries <= '0;
              if (next_v) begin st <= ST_GAP; cnt <= CW'(GAP_TICKS); cur <= next_i; end
              else begin st <= ST_WAIT; cnt <= pause; end
            end else tries <= tries + 8'd1;
          end
        end
        default: begin
          if (tick) begin
            if (cnt <= CW'(1)) begin st <= ST_BUSY; tries <= '0; end
            else cnt <= cnt - CW'(1);
          end
        end
      endcase
      for (int i = 0; i < SLOTS; i++)
        if (en_mask[i] && !en_q[i]) res[i] <= ERR_FRESH;
      if (q_rd) begin
        if (!q_sel[3])
          q_data <= en_mask[q_sel[SW-1:0]] ? res[q_sel[SW-1:0]] : ERR_DIS;
        else if (q_sel == 4'd8) begin
          q_data <= mx_v ? mx : ERR_NOMAX;
          lm_ok  <= mx_v;
          lm_idx <= mx_i;
        end else if (q_sel == 4'd10)
          q_data <= lm_ok ? 16'(lm_idx) : ERR_NOMAX;
        else
          q_data <= '0;
      end
    end
  end

  AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_done |=> rd_req && $stable(rd_slot)); // R9
  AST_GAP_AFTER_OK: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && rd_done && rd_ok |=> !rd_req); // R2
  AST_RETRY_SAME_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && rd_done && !rd_ok && tries != retry_max |=> rd_req && $stable(rd_slot)); // R4
  AST_CODE0_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_WAIT && !poll_req && (delay_code == 3'd0 || delay_code == 3'd7) |=> !rd_req); // R3
  AST_DIS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    q_rd && !q_sel[3] && !en_mask[q_sel[SW-1:0]] |=> q_data == ERR_DIS); // R5
  AST_MAX_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    q_rd && q_sel == 4'd8 |=> q_data == ERR_NOMAX || q_data[15:9] != 7'h40); // R6
endmodule

// File: tb/poll_sched_tb_top.sv
module poll_sched_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, tick, poll_req, rd_req, rd_done, rd_ok, q_rd;
  logic [7:0] en_mask, retry_max;
  logic [2:0] delay_code, rd_slot;
  logic [15:0] rd_data, q_data;
  logic [3:0] q_sel;

  poll_sched dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en_mask(en_mask), .delay_code(delay_code),
    .retry_max(retry_max), .poll_req(poll_req), .rd_req(rd_req), .rd_slot(rd_slot),
    .rd_done(rd_done), .rd_ok(rd_ok), .rd_data(rd_data), .q_rd(q_rd), .q_sel(q_sel),
    .q_data(q_data)
  );

  int checks = 0, errors = 0;
  logic [15:0] exp_res [8];
  int fails [8];
  int log_slot [512];
  int log_gap [512];
  int log_n = 0, low_cnt = 0;
  bit rnd_mode = 1'b0;
  logic [15:0] d_data [8];
  bit d_fail [8];

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic chk(input string r, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic q(input logic [3:0] s, output logic [15:0] v);
    @(negedge clk); q_sel = s; q_rd = 1'b1;
    @(negedge clk); q_rd = 1'b0; v = q_data;
  endtask

  task automatic pulse_poll();
    @(negedge clk); poll_req = 1'b1;
    @(negedge clk); poll_req = 1'b0;
  endtask

  task automatic wait_idle();
    int k = 0;
    while (k < 40) begin @(negedge clk); k = rd_req ? 0 : k + 1; end
  endtask

  task automatic set_mask(input logic [7:0] m);
    @(negedge clk);
    for (int i = 0; i < 8; i++)
      if (m[i] && !en_mask[i]) begin exp_res[i] = 16'h8102; fails[i] = 0; end
    en_mask = m;
  endtask

  function automatic logic [15:0] bmax(output int idx);
    bit v = 1'b0;
    logic [15:0] b = '0;
    idx = -1;
    for (int i = 0; i < 8; i++)
      if (en_mask[i] && exp_res[i][15:9] != 7'h40 && (!v || $signed(exp_res[i]) > $signed(b))) begin
        v = 1'b1; b = exp_res[i]; idx = i;
      end
    return v ? b : 16'h8103;
  endfunction

  task automatic check_all();
    logic [15:0] v, m;
    int idx;
    for (int i = 0; i < 8; i++) begin
      q(4'(i), v);
      chk("R5 slot result", v, en_mask[i] ? exp_res[i] : 16'h8101);
    end
    m = bmax(idx);
    q(4'd8, v);  chk("R6 max", v, m);
    q(4'd10, v); chk("R7 max address", v, idx >= 0 ? 16'(idx) : 16'h8103);
  endtask

  // transaction engine model
  initial begin
    rd_done = 1'b0; rd_ok = 1'b0; rd_data = '0;
    forever begin
      @(negedge clk);
      if (rst_n === 1'b1 && rd_req === 1'b1) begin
        int s, l;
        logic ok;
        logic [15:0] d;
        s = int'(rd_slot);
        if (log_n < 512) begin log_slot[log_n] = s; log_gap[log_n] = low_cnt; log_n++; end
        if (rnd_mode) begin
          l = int'($urandom % 3); ok = ($urandom % 3) != 0;
          d = ($urandom % 5 == 0) ? {7'h40, 9'($urandom)} : 16'($urandom);
        end else begin
          l = 1; ok = !d_fail[s]; d = d_data[s];
        end
        repeat (l) @(negedge clk);
        rd_done = 1'b1; rd_ok = ok; rd_data = d;
        @(negedge clk);
        rd_done = 1'b0; rd_ok = 1'b0;
        if (ok) begin exp_res[s] = d; fails[s] = 0; end
        else begin
          fails[s]++;
          if (fails[s] > int'(retry_max)) begin exp_res[s] = 16'h8100; fails[s] = 0; end
        end
        low_cnt = rd_req ? 0 : 1;
      end else low_cnt++;
    end
  end

  initial begin
    #(10 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    int base, n2;
    int mult [6] = '{1, 2, 4, 20, 40, 200};
    void'($urandom(32'd2024));
    rst_n = 1'b0; tick = 1'b1; en_mask = '0; delay_code = 3'd0; retry_max = 8'd3;
    poll_req = 1'b0; q_rd = 1'b0; q_sel = '0;
    for (int i = 0; i < 8; i++) begin exp_res[i] = 16'h8102; fails[i] = 0; d_fail[i] = 1'b0; d_data[i] = 16'h0000; end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 q_data after reset", q_data, 16'h0000);
    chk("R1 no request after reset", {15'd0, rd_req}, 16'd0);
    repeat (20) @(negedge clk);
    chk("R3 code 0 starts nothing", 16'(log_n), 16'd0);
    q(4'd0, v);  chk("R5 disabled slot", v, 16'h8101);
    q(4'd8, v);  chk("R6 max with none enabled", v, 16'h8103);
    q(4'd10, v); chk("R7 address before valid max", v, 16'h8103);
    q(4'd15, v); chk("R10 unsupported selector", v, 16'h0000);

    set_mask(8'h05);
    q(4'd0, v); chk("R5 newly enabled slot", v, 16'h8102);
    d_data[0] = 16'hFF00; d_data[1] = 16'h8001; d_data[2] = 16'h0100; d_data[3] = 16'h0100;
    pulse_poll();
    wait_idle();
    chk("R8 one sweep after poll", 16'(log_n), 16'd2);
    chk("R9 first slot", 16'(log_slot[0]), 16'd0);
    chk("R9 skips disabled slot", 16'(log_slot[1]), 16'd2);
    chk("R2 gap between reads", 16'(log_gap[1]), 16'(5));
    check_all();

    base = log_n;
    pulse_poll();
    repeat (3) @(negedge clk);
    pulse_poll();
    wait_idle();
    chk("R8 poll during sweep dropped", 16'(log_n - base), 16'd2);

    for (int c = 1; c <= 6; c++) begin
      base = log_n;
      @(negedge clk); delay_code = 3'(c);
      while (log_n < base + 4) @(negedge clk);
      delay_code = 3'd0;
      wait_idle();
      chk("R3 pause after sweep", 16'(log_gap[base + 2]), 16'(5 * mult[c - 1]));
      chk("R2 gap inside sweep", 16'(log_gap[base + 3]), 16'(5));
    end
    base = log_n;
    @(negedge clk); delay_code = 3'd7;
    repeat (60) @(negedge clk);
    chk("R3 code 7 starts nothing", 16'(log_n - base), 16'd0);
    delay_code = 3'd0;

    retry_max = 8'd1; d_fail[2] = 1'b1;
    base = log_n;
    pulse_poll();
    wait_idle();
    n2 = 0;
    for (int i = base; i < log_n; i++) if (log_slot[i] == 2) n2++;
    chk("R4 attempts with one retry", 16'(n2), 16'd2);
    chk("R4 retry reissued at once", 16'(log_gap[log_n - 1]), 16'd0);
    q(4'd2, v); chk("R4 exhausted retries", v, 16'h8100);
    d_fail[2] = 1'b0;

    set_mask(8'h0F);
    pulse_poll();
    wait_idle();
    q(4'd8, v);  chk("R6 signed max with tie", v, 16'h0100);
    q(4'd10, v); chk("R7 tie goes to lowest slot", v, 16'h0002);
    q(4'd3, v);  chk("R10 slot read", v, 16'h0100);
    q(4'd10, v); chk("R7 address held", v, 16'h0002);
    d_data[0] = 16'h81FF; d_data[2] = 16'h8050; d_data[3] = 16'h8000;
    pulse_poll();
    wait_idle();
    q(4'd8, v);  chk("R6 all errors", v, 16'h8103);
    q(4'd10, v); chk("R7 after failed max", v, 16'h8103);
    set_mask(8'h0E);
    q(4'd0, v); chk("R5 disabled again", v, 16'h8101);
    set_mask(8'h0F);
    q(4'd0, v); chk("R5 re-enabled slot", v, 16'h8102);

    rnd_mode = 1'b1;
    for (int r = 0; r < 10; r++) begin
      retry_max = 8'($urandom % 3);
      set_mask(8'($urandom));
      pulse_poll();
      wait_idle();
      check_all();
    end
    finish_run();
  end
endmodule